// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block is a two-operand integer adder/subtractor with a registered condition-flag word. It takes operands `opnd_x` and `opnd_y` and a single select bit, and it drives their sum or difference on `res` combinationally. From the result it derives four condition flags: negative, zero, signed overflow and carry. It loads them into a status register on a rising clock edge, but only while `flag_load` is high. The operand width is the parameter `W`, which defaults to 8.

Branch or compare logic around the unit reads the stored flags after a compare-style operation. For that reason the carry flag on a subtract means "no borrow": it is high when `opnd_x >= opnd_y` as unsigned numbers. The overflow and carry flags are formed from the most significant bits of the two operands and the result. The unit does not use a widened internal sum to form them.

The design has no sequencing states. The only stored state is the flag register. It has two transitions: load (when `flag_load` is high at a clock edge) and hold (when it is low). An asynchronous active-low reset clears the register.

Top module: `nzvc_alu`

## Requirements
- R1: With `sel_sub` = 0, `res` equals (`opnd_x` + `opnd_y`) modulo 2^W in the same cycle.
- R2: With `sel_sub` = 1, `res` equals (`opnd_x` - `opnd_y`) modulo 2^W in the same cycle. `res` follows the operands whatever the level of `flag_load`.
- R3: After a load, `flg_n` equals bit W-1 of the result that was present at that clock edge.
- R4: After a load, `flg_z` is 1 exactly when every bit of that result was 0.
- R5: After an add is loaded, `flg_c` is 1 exactly when the unsigned sum exceeds 2^W-1. For example, 255+5 gives `res` = 4 with `flg_c` = 1.
- R6: After a subtract is loaded, `flg_c` is 0 when `opnd_x` < `opnd_y` as unsigned numbers (a borrow) and 1 otherwise.
- R7: After a load, `flg_v` is 1 exactly when the true two's-complement sum or difference lies outside [-2^(W-1), 2^(W-1)-1]. For example, -100-100 sets it and 10-5 clears it.
- R8: At a clock edge with `flag_load` = 0, all four flags keep their values.
- R9: While `rst_n` is low, all four flags are 0.
- R10: With W = 8, the subtract 32-129 gives `res` = 159 and flags N,Z,V,C = 1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opnd_x | input | W | First operand (minuend for subtract) |
| opnd_y | input | W | Second operand (subtrahend for subtract) |
| sel_sub | input | 1 | 0 selects add, 1 selects subtract |
| flag_load | input | 1 | When high, the flags are stored at the next rising edge |
| res | output | W | Combinational sum or difference |
| flg_n | output | 1 | Stored negative flag |
| flg_z | output | 1 | Stored zero flag |
| flg_v | output | 1 | Stored signed-overflow flag |
| flg_c | output | 1 | Stored carry flag (no-borrow on subtract) |

## Verification
On every cycle, the bound checker compares `res` against a plain modular add or subtract. After each load, it checks each stored flag against values it computes from widened signed and unsigned arithmetic. It also checks that the flags stay stable when no load occurs and stay clear during reset. The bench's scenarios are what show concrete wrap-around values: the 32-129 case, the carry convention at the boundaries 0-1 and x-x, and positive and negative overflow from both directions. The scenarios also show that a flag word survives a run of unloaded operations and that a mid-run reset wipes it.

// File: rtl/nzvc_alu_pkg.sv
package nzvc_alu_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

    localparam nzvc_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/nzvc_addsub_core.sv
module nzvc_addsub_core
    import nzvc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] r_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] y_eff;
    logic [W-1:0] cin_vec;

    // Subtract is x + ~y + 1 so that one adder serves both operations.
    always_comb begin
        unique case (op_i)
            OP_SUB: begin
                y_eff   = ~y_i;
                cin_vec = ONE;
            end
            default: begin
                y_eff   = y_i;
                cin_vec = '0;
            end
        endcase
        r_o = x_i + y_eff + cin_vec;
    end

endmodule

// File: rtl/nzvc_flag_gen.sv
module nzvc_flag_gen
    import nzvc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         x_msb_i,
    input  logic         y_msb_i,
    input  logic [W-1:0] r_i,
    input  alu_op_e      op_i,
    output nzvc_t        flags_o
);
    localparam int MSB = W - 1;

    logic ym;
    logic rm;

    // The effective second-operand sign is the one the adder really sees.
    // Taking it this way turns the add equations into the subtract ones
    // and makes carry mean "no borrow" on a subtract.
    always_comb begin
        unique case (op_i)
            OP_SUB:  ym = ~y_msb_i;
            default: ym = y_msb_i;
        endcase
        rm = r_i[MSB];

        flags_o.n = rm;
        flags_o.z = ~|r_i;
        flags_o.v = (x_msb_i & ym & ~rm) | (~x_msb_i & ~ym & rm);
        flags_o.c = (x_msb_i & ym) | (x_msb_i & ~rm) | (ym & ~rm);
    end

endmodule

// File: rtl/nzvc_flag_reg.sv
module nzvc_flag_reg
    import nzvc_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  nzvc_t next_i,
    output nzvc_t flags_o
);
    typedef enum logic {
        FR_HOLD = 1'b0,
        FR_LOAD = 1'b1
    } fr_act_e;

    fr_act_e act;
    nzvc_t   flags_d;

    always_comb begin
        act = load_i ? FR_LOAD : FR_HOLD;
        unique case (act)
            FR_LOAD: flags_d = next_i;
            default: flags_d = flags_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= FLAGS_CLEAR;
        else        flags_o <= flags_d;
    end

endmodule

// File: rtl/nzvc_alu.sv
module nzvc_alu
    import nzvc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_x,
    input  logic [W-1:0] opnd_y,
    input  logic         sel_sub,
    input  logic         flag_load,
    output logic [W-1:0] res,
    output logic         flg_n,
    output logic         flg_z,
    output logic         flg_v,
    output logic         flg_c
);
    localparam int MSB = W - 1;

    alu_op_e op_sel;
    nzvc_t   flags_next;
    nzvc_t   flags_q;

    assign op_sel = sel_sub ? OP_SUB : OP_ADD;

    nzvc_addsub_core #(.W(W)) u_core (
        .x_i (opnd_x),
        .y_i (opnd_y),
        .op_i(op_sel),
        .r_o (res)
    );

    nzvc_flag_gen #(.W(W)) u_fgen (
        .x_msb_i(opnd_x[MSB]),
        .y_msb_i(opnd_y[MSB]),
        .r_i    (res),
        .op_i   (op_sel),
        .flags_o(flags_next)
    );

    nzvc_flag_reg u_freg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flag_load),
        .next_i (flags_next),
        .flags_o(flags_q)
    );

    assign flg_n = flags_q.n;
    assign flg_z = flags_q.z;
    assign flg_v = flags_q.v;
    assign flg_c = flags_q.c;

endmodule

// File: rtl/nzvc_alu_chk.sv
module nzvc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_x,
    input logic [W-1:0] opnd_y,
    input logic         sel_sub,
    input logic         flag_load,
    input logic [W-1:0] res,
    input logic         flg_n,
    input logic         flg_z,
    input logic         flg_v,
    input logic         flg_c
);
    localparam int MSB = W - 1;

    logic [W:0]   wide_u;
    logic [W:0]   wide_s;
    logic         exp_c;
    logic         exp_v;

    // Reference built from widened arithmetic rather than from sign bits.
    always_comb begin
        if (sel_sub) begin
            wide_u = {1'b0, opnd_x} - {1'b0, opnd_y};
            wide_s = {opnd_x[MSB], opnd_x} - {opnd_y[MSB], opnd_y};
            exp_c  = ~wide_u[W];
        end else begin
            wide_u = {1'b0, opnd_x} + {1'b0, opnd_y};
            wide_s = {opnd_x[MSB], opnd_x} + {opnd_y[MSB], opnd_y};
            exp_c  = wide_u[W];
        end
        exp_v = wide_s[W] ^ wide_s[MSB];
    end

    a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_sub |-> res == W'(opnd_x + opnd_y));

    a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sub |-> res == W'(opnd_x - opnd_y));

    a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> flg_n == $past(res[MSB]));

    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> flg_z == ($past(res) == '0));

    // Covers R5 (add) and R6 (subtract, no-borrow convention).
    a_r5_r6_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> flg_c == $past(exp_c));

    a_r7_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> flg_v == $past(exp_v));

    a_r8_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_load |=> $stable({flg_n, flg_z, flg_v, flg_c}));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r9_reset_clear: assert ({flg_n, flg_z, flg_v, flg_c} == 4'b0000);
        end
    end

endmodule

bind nzvc_alu nzvc_alu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_x   (opnd_x),
    .opnd_y   (opnd_y),
    .sel_sub  (sel_sub),
    .flag_load(flag_load),
    .res      (res),
    .flg_n    (flg_n),
    .flg_z    (flg_z),
    .flg_v    (flg_v),
    .flg_c    (flg_c)
);

// File: tb/tb_nzvc_alu.sv
`timescale 1ns/1ps
module tb_nzvc_alu;
    localparam int W  = 8;
    localparam int NV = 13;
    localparam int TP = 8;

    // Vector: {x, y, sub, expected result, expected NZVC}
    localparam logic [28:0] VEC [NV] = '{
        {8'd10,  8'd5,   1'b0, 8'd15,  4'b0000},
        {8'd255, 8'd5,   1'b0, 8'd4,   4'b0001},
        {8'd96,  8'd64,  1'b0, 8'd160, 4'b1010},
        {8'd224, 8'd64,  1'b0, 8'd32,  4'b0001},
        {8'd128, 8'd128, 1'b0, 8'd0,   4'b0111},
        {8'd127, 8'd1,   1'b0, 8'd128, 4'b1010},
        {8'd200, 8'd100, 1'b0, 8'd44,  4'b0001},
        {8'd10,  8'd5,   1'b1, 8'd5,   4'b0001},
        {8'd156, 8'd100, 1'b1, 8'd56,  4'b0011},
        {8'd32,  8'd129, 1'b1, 8'd159, 4'b1010},
        {8'd5,   8'd5,   1'b1, 8'd0,   4'b0101},
        {8'd0,   8'd1,   1'b1, 8'd255, 4'b1000},
        {8'd128, 8'd1,   1'b1, 8'd127, 4'b0011}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [W-1:0] opnd_x = '0;
    logic [W-1:0] opnd_y = '0;
    logic         sel_sub = 1'b0;
    logic         flag_load = 1'b0;
    logic [W-1:0] res;
    logic         flg_n, flg_z, flg_v, flg_c;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(TP/2) clk = ~clk;

    nzvc_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .sel_sub(sel_sub), .flag_load(flag_load), .res(res),
        .flg_n(flg_n), .flg_z(flg_z), .flg_v(flg_v), .flg_c(flg_c)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Widened reference model: returns {result, N, Z, V, C}.
    function automatic logic [11:0] model(input logic [7:0] a, input logic [7:0] b, input logic s);
        int ua, ub, sa, sb, ut, st;
        logic [7:0] r;
        logic n, z, v, c;
        ua = int'(a); ub = int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        if (s) begin ut = ua - ub; st = sa - sb; c = (ut >= 0); end
        else   begin ut = ua + ub; st = sa + sb; c = (ut > 255); end
        r = ut[7:0];
        n = r[7];
        z = (r == 8'd0);
        v = (st > 127) || (st < -128);
        return {r, n, z, v, c};
    endfunction

    function automatic logic [3:0] flags_now();
        return {flg_n, flg_z, flg_v, flg_c};
    endfunction

    // Drive at negedge, check result, load on posedge, check flags after.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic s,
                         input logic ld);
        @(negedge clk);
        opnd_x = a; opnd_y = b; sel_sub = s; flag_load = ld;
        #1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [11:0] m;
        logic [3:0]  held;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset flags", flags_now(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1..R7, R10 (32-129 is row 9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            opnd_x = VEC[i][28:21]; opnd_y = VEC[i][20:13];
            sel_sub = VEC[i][12]; flag_load = 1'b1;
            #1;
            chk(sel_sub ? "R2 sub result" : "R1 add result", res, VEC[i][11:4]);
            @(posedge clk);
            #1;
            chk(i == 9 ? "R10 32-129 flags" : "R3 R4 R5 R6 R7 flags",
                flags_now(), VEC[i][3:0]);
        end

        // Random sweep against the widened model
        for (int k = 0; k < 150; k++) begin
            logic [7:0] a, b;
            logic s;
            a = 8'($urandom); b = 8'($urandom); s = 1'($urandom);
            m = model(a, b, s);
            @(negedge clk);
            opnd_x = a; opnd_y = b; sel_sub = s; flag_load = 1'b1;
            #1;
            chk("R1 R2 random result", res, m[11:4]);
            @(posedge clk);
            #1;
            chk("R3 R4 R5 R6 R7 random flags", flags_now(), m[3:0]);
        end

        // R6 boundaries: equal operands keep carry, 0-255 borrows
        apply(8'd200, 8'd200, 1'b1, 1'b1);
        chk("R6 x-x carry set", flg_c, 1'b1);
        apply(8'd0, 8'd255, 1'b1, 1'b1);
        chk("R6 0-255 borrow clears carry", flg_c, 1'b0);
        chk("R2 0-255 result", res, 8'd1);

        // R8 hold: load a known word, then run unloaded ops
        apply(8'd128, 8'd128, 1'b0, 1'b1);
        held = flags_now();
        chk("R8 loaded word", held, 4'b0111);
        apply(8'd1, 8'd2, 1'b1, 1'b0);
        chk("R2 result with load low", res, 8'd255);
        chk("R8 flags held after sub", flags_now(), held);
        apply(8'd10, 8'd5, 1'b0, 1'b0);
        chk("R1 result with load low", res, 8'd15);
        chk("R8 flags held after add", flags_now(), held);

        // R9 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 async clear", flags_now(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        flag_load = 1'b0;
        @(posedge clk);
        #1;
        chk("R9 stays clear after release", flags_now(), 4'b0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(TP * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule